// File: doc/BRIEF.md
# Programmable Product-Term Array Core

This block is the logic core of a small programmable array device. Sixteen array inputs (dedicated inputs together with feedback from output cells) are each split into a true line and an inverted line. This gives thirty-two array columns. Sixty-four programmable AND terms each pick any subset of those columns. The terms are wired in fixed groups of eight to eight OR gates. Only the AND connections are programmable.

The connection pattern is held in a 2048-bit configuration register. It is loaded serially, one bit per clock, while a shift enable is high. Evaluation from the array inputs to the outputs is purely combinational.

For each output group the block presents all eight raw terms and the OR of all eight. A downstream output cell can then pick one term of a group as a buffer enable and sum the other seven itself. Two degenerate cases have fixed meanings. A term with no connections reads HIGH. A term that connects both polarities of one input reads LOW.

Top module: `pterm_array`

## Requirements
- R1: Reset (rstN low) clears every connection bit. While the configuration is cleared, all 64 terms and all 8 sums read HIGH, whatever arrayIn holds.
- R2: The configuration is loaded first bit first. Connection bit index r*32+c links term r to column c. Column 2i carries arrayIn[i] and column 2i+1 carries its inverse. A 1 means connected. After 2048 shifts, the first bit shifted in is at index 2047 (term 63, column 31) and the last bit is at index 0 (term 0, column 0).
- R3: While shiftEn is low, the configuration does not change, whatever shiftData does.
- R4: shiftEn and shiftData are registered once before use. A bit presented at clock edge k takes effect on the outputs only after edge k+1.
- R5: Term r is the AND of every column connected to it.
- R6: A term with no connected column reads HIGH.
- R7: A term connected to both the true and the inverted column of one input reads LOW for every input value.
- R8: termOut[8g+k] is term 8g+k. sumOut[g] is the OR of terms 8g to 8g+7.
- R9: termOut and sumOut follow a change on arrayIn within the same clock cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration path |
| rstN | input | 1 | Active-low asynchronous reset; clears the configuration |
| shiftEn | input | 1 | Shift one configuration bit on this edge |
| shiftData | input | 1 | Serial configuration bit |
| arrayIn | input | 16 | Array input signals |
| termOut | output | 64 | Raw product terms, eight per output group |
| sumOut | output | 8 | OR of each group of eight terms |

## Verification
Array results are combinational. The bench changes arrayIn in the low phase of the clock and samples termOut and sumOut one nanosecond later, before any edge. A configuration bit reaches the outputs two rising edges after it is driven: one edge to register it, and one edge to shift it in. The bench therefore drops shiftEn after the last bit and waits one further full cycle before checking. The latency check samples between those two edges and expects the old value there. A random 16-bit input pattern is applied for each check. Expected terms and sums come from a bench model of the loaded bit vector.

// File: rtl/pterm_pkg.sv
package pterm_pkg;
  localparam int DEF_INPUTS        = 16;
  localparam int DEF_OUTPUTS       = 8;
  localparam int DEF_TERMS_PER_OUT = 8;

  // Strobes from the control stage to the datapath
  typedef struct packed {
    logic shift;
    logic dataBit;
  } ctrlStrobe_t;
endpackage

// File: rtl/pterm_ctrl.sv
module pterm_ctrl
  import pterm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        shiftEn,
  input  logic        shiftData,
  output ctrlStrobe_t strobe
);

  // Register the serial interface once so that the wide shift register
  // sees clean, edge-aligned strobes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobe <= '0;
    end else begin
      strobe.shift   <= shiftEn;
      strobe.dataBit <= shiftData;
    end
  end

  AST_SAMPLE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> strobe.shift); // R4

endmodule

// File: rtl/pterm_datapath.sv
module pterm_datapath
  import pterm_pkg::*;
#(
  parameter int NUM_INPUTS    = DEF_INPUTS,
  parameter int NUM_OUTPUTS   = DEF_OUTPUTS,
  parameter int TERMS_PER_OUT = DEF_TERMS_PER_OUT,
  localparam int NUM_COLS     = 2 * NUM_INPUTS,
  localparam int NUM_TERMS    = NUM_OUTPUTS * TERMS_PER_OUT,
  localparam int CFG_BITS     = NUM_TERMS * NUM_COLS
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [NUM_INPUTS-1:0] arrayIn,
  output logic [NUM_TERMS-1:0]  termOut,
  output logic [NUM_OUTPUTS-1:0] sumOut
);

  logic [CFG_BITS-1:0] cfg;
  logic [NUM_COLS-1:0] cols;

  // Serial configuration store; first bit shifted ends at the top index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (strobe.shift) begin
      cfg <= {cfg[CFG_BITS-2:0], strobe.dataBit};
    end
  end

  // True / inverted column pairs
  for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_cols
    assign cols[2*i]   = arrayIn[i];
    assign cols[2*i+1] = ~arrayIn[i];
  end

  // Programmable AND plane
  for (genvar r = 0; r < NUM_TERMS; r++) begin : g_row
    logic [NUM_COLS-1:0]   rowBits;
    logic [NUM_INPUTS-1:0] bothPol;
    assign rowBits    = cfg[r*NUM_COLS +: NUM_COLS];
    assign termOut[r] = &(~rowBits | cols);

    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_pol
      assign bothPol[i] = rowBits[2*i] & rowBits[2*i+1];
    end

    AST_EMPTY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      (rowBits == '0) |-> termOut[r]); // R6
    AST_CONFLICT_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (|bothPol) |-> !termOut[r]); // R7
  end

  // Fixed OR plane
  for (genvar g = 0; g < NUM_OUTPUTS; g++) begin : g_grp
    assign sumOut[g] = |termOut[g*TERMS_PER_OUT +: TERMS_PER_OUT];

    AST_GROUP_SUM: assert property (@(posedge clk) disable iff (!rstN)
      ($countones(termOut[g*TERMS_PER_OUT +: TERMS_PER_OUT]) == 0) |-> !sumOut[g]); // R8
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> $stable(cfg)); // R3
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> (cfg[0] == $past(strobe.dataBit))); // R2
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (&termOut)); // R1

endmodule

// File: rtl/pterm_array.sv
module pterm_array
  import pterm_pkg::*;
#(
  parameter int NUM_INPUTS    = DEF_INPUTS,
  parameter int NUM_OUTPUTS   = DEF_OUTPUTS,
  parameter int TERMS_PER_OUT = DEF_TERMS_PER_OUT,
  localparam int NUM_TERMS    = NUM_OUTPUTS * TERMS_PER_OUT
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   shiftEn,
  input  logic                   shiftData,
  input  logic [NUM_INPUTS-1:0]  arrayIn,
  output logic [NUM_TERMS-1:0]   termOut,
  output logic [NUM_OUTPUTS-1:0] sumOut
);

  ctrlStrobe_t strobe;

  pterm_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .shiftEn   (shiftEn),
    .shiftData (shiftData),
    .strobe    (strobe)
  );

  pterm_datapath #(
    .NUM_INPUTS    (NUM_INPUTS),
    .NUM_OUTPUTS   (NUM_OUTPUTS),
    .TERMS_PER_OUT (TERMS_PER_OUT)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .arrayIn (arrayIn),
    .termOut (termOut),
    .sumOut  (sumOut)
  );

endmodule

// File: tb/test_pterm_array.sv
module test_pterm_array;
  localparam int NI = 16;
  localparam int NC = 32;
  localparam int NT = 64;
  localparam int NG = 8;
  localparam int NB = NT * NC;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          shiftEn = 1'b0;
  logic          shiftData = 1'b0;
  logic [NI-1:0] arrayIn = '0;
  logic [NT-1:0] termOut;
  logic [NG-1:0] sumOut;

  int checks = 0;
  int fails  = 0;
  logic [NB-1:0] model;

  always #2.5 clk = ~clk;

  pterm_array i_pterm_array (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .shiftData(shiftData),
    .arrayIn(arrayIn), .termOut(termOut), .sumOut(sumOut)
  );

  function automatic logic [NT-1:0] expTerms(input logic [NB-1:0] c, input logic [NI-1:0] x);
    logic [NT-1:0] t;
    for (int r = 0; r < NT; r++) begin
      t[r] = 1'b1;
      for (int k = 0; k < NC; k++) begin
        logic colVal;
        colVal = (k % 2 == 0) ? x[k/2] : ~x[k/2];
        if (c[r*NC+k] && !colVal) t[r] = 1'b0;
      end
    end
    return t;
  endfunction

  function automatic logic [NG-1:0] expSums(input logic [NT-1:0] t);
    logic [NG-1:0] s;
    for (int g = 0; g < NG; g++) s[g] = |t[g*8 +: 8];
    return s;
  endfunction

  task automatic checkVal(input string req, input logic [NT-1:0] act, input logic [NT-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    logic [NT-1:0] t;
    t = expTerms(model, arrayIn);
    checkVal({req, " terms"}, termOut, t);
    checkVal({req, " sums R8"}, {56'd0, sumOut}, {56'd0, expSums(t)});
  endtask

  task automatic loadCfg(input logic [NB-1:0] v);
    for (int idx = NB - 1; idx >= 0; idx--) begin
      @(negedge clk);
      shiftEn   = 1'b1;
      shiftData = v[idx];
    end
    @(negedge clk);
    shiftEn = 1'b0;
    @(negedge clk);
    model = v;
  endtask

  task automatic randomInputs(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      arrayIn = NI'($urandom);
      #1;
      checkAll(req);
    end
  endtask

  initial begin
    logic [NB-1:0] v;
    logic [NT-1:0] snapT;
    void'($urandom(32'd7351));
    model = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: cleared configuration, all terms and sums high
    arrayIn = 16'h0000; #1;
    checkVal("R1 terms after reset", termOut, {NT{1'b1}});
    checkVal("R1 sums after reset", {56'd0, sumOut}, {56'd0, {NG{1'b1}}});
    arrayIn = 16'hFFFF; #1;
    checkVal("R1 terms any input", termOut, {NT{1'b1}});

    // R4: one bit shifted; not visible after the first edge, visible after the second
    @(negedge clk);
    arrayIn = 16'h0000;
    shiftEn = 1'b1; shiftData = 1'b1;
    @(negedge clk);
    shiftEn = 1'b0; shiftData = 1'b0;
    #1;
    checkVal("R4 not yet applied", {63'd0, termOut[0]}, 64'd1);
    @(negedge clk); #1;
    checkVal("R4 applied after second edge (R2 index 0 = term0 col0)", {63'd0, termOut[0]}, 64'd0);

    // R2 bit order: first shifted bit = term 63 col 31 (inverse of input 15)
    v = '0;
    v[NB-1] = 1'b1;
    v[0]    = 1'b1;
    loadCfg(v);
    arrayIn = 16'h8001; #1;
    checkVal("R2 order high input15", {62'd0, termOut[63], termOut[0]}, 64'd1);
    arrayIn = 16'h0000; #1;
    checkVal("R2 order low inputs", {62'd0, termOut[63], termOut[0]}, 64'd2);
    checkAll("R2 full");

    // R6/R7 directed: row 5 conflicts on input 3, row 9 empty, row 12 single term
    v = '0;
    v[5*NC+6]  = 1'b1;
    v[5*NC+7]  = 1'b1;
    v[12*NC+4] = 1'b1;
    v[12*NC+9] = 1'b1;
    loadCfg(v);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      arrayIn = NI'($urandom);
      #1;
      checkVal("R7 conflicting term low", {63'd0, termOut[5]}, 64'd0);
      checkVal("R6 empty term high", {63'd0, termOut[9]}, 64'd1);
      checkVal("R5 two-column term", {63'd0, termOut[12]},
               {63'd0, arrayIn[2] & ~arrayIn[4]});
    end
    checkAll("R5 R6 R7 directed");

    // R9 combinational follow within one low phase
    @(negedge clk);
    arrayIn = 16'h0004; #0.5;
    checkVal("R9 first value", {63'd0, termOut[12]}, 64'd1);
    arrayIn = 16'h0014; #0.5;
    checkVal("R9 second value same cycle", {63'd0, termOut[12]}, 64'd0);

    // Random sparse configurations with random inputs (R5, R8)
    for (int cfgN = 0; cfgN < 4; cfgN++) begin
      for (int b = 0; b < NB; b++) v[b] = (($urandom % 24) == 0);
      for (int r = 0; r < NT; r += 7) v[r*NC +: NC] = '0;
      loadCfg(v);
      randomInputs("R5 random", 20);

      // R3: shiftData toggles while shiftEn low; outputs must not change
      @(negedge clk);
      arrayIn = NI'($urandom); #1;
      snapT = termOut;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        shiftData = ~shiftData;
      end
      @(negedge clk); @(negedge clk); #1;
      checkVal("R3 idle shiftData ignored", termOut, snapT);
      checkAll("R3 idle model");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule